// File: doc/BRIEF.md
# Field-Inversion Byte Substitution Unit

This unit takes one byte and returns its AES substitution value. Nothing is looked up in a table. The unit first finds the multiplicative inverse of the byte in the field of 256 elements defined by x^8 + x^4 + x^3 + x + 1 (0x11B). It does this by raising the byte to the power 254 with a left-to-right square-and-multiply chain. Every multiplication goes through one bit-serial shift-and-XOR multiplier.

The inverse then passes through the fixed affine map of the cipher to give the result. The exponent is a constant, so every input runs the same 13 multiplications and takes the same number of cycles, including zero. A byte enters on a valid/ready handshake. The result leaves on a second valid/ready handshake and is held until it is taken. The unit processes one byte at a time.

Top module: `sbox_fermat_unit`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `out_valid` are both low. After release, `in_ready` goes high on the third rising clock edge.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result has been taken, and `in_ready` and `out_valid` are never high together.
- R3: The result is y = A(inv(x)). inv(x) is the inverse of x modulo 0x11B, with inv(0x00) = 0x00. A sets output bit i to b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ bit i of 0x63. Bit 0 is the least significant bit.
- R4: Input 0x00 yields 0x63.
- R5: Input 0x01 yields 0x7C, and input 0x53 yields 0xED.
- R6: `out_valid` rises exactly 117 rising edges after the accepting edge (13 multiplications of 9 cycles each), whatever the input value.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` holds its value.
- R8: The result is taken on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high in the following cycle. `in_valid` and `in_byte` activity during a computation has no effect on that computation's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Unit is idle and will accept a byte |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_byte | output | 8 | Substituted byte |

## Verification
Each step of the chain feeds the next, so a wrong partial power, a skipped squaring or a bad reduction step corrupts the final inverse. The error is seen on `out_byte` once `out_valid` rises, 117 cycles after acceptance. A sequencer that ends the chain early or runs an extra step shows up as a shift in the `out_valid` edge against the fixed latency. A handshake state that leaks shows up as `in_ready` out of step with a per-clock model. Inputs are chosen so that several carry-out and reduction patterns of the multiplier are used, together with zero, one and 0xFF.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

  localparam int unsigned SBX_W = 8;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_IDLE = 2'd1,
    ST_CALC = 2'd2,
    ST_HOLD = 2'd3
  } sbx_state_e;

endpackage

// File: rtl/sbx_rst_sync.sv
module sbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gf_serial_mul.sv
module gf_serial_mul #(
  parameter int unsigned   W    = 8,
  parameter logic [W-1:0]  POLY = 8'h1B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         done,
  output logic [W-1:0] product
);

  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  logic [W-1:0]  mcand_q, mcand_d;
  logic [W-1:0]  mplier_q, mplier_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [CW-1:0] step_q, step_d;
  logic          run_q, run_d;
  logic          done_q, done_d;
  logic [W-1:0]  mcand_x;

  // multiply-by-x with conditional reduction
  always_comb begin
    mcand_x = {mcand_q[W-2:0], 1'b0} ^ (mcand_q[W-1] ? POLY : '0);
  end

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc_q;
    step_d   = step_q;
    run_d    = run_q;
    done_d   = 1'b0;
    if (start) begin
      mcand_d  = op_a;
      mplier_d = op_b;
      acc_d    = '0;
      step_d   = LAST_STEP;
      run_d    = 1'b1;
    end else if (run_q) begin
      acc_d    = acc_q ^ (mplier_q[0] ? mcand_q : '0);
      mcand_d  = mcand_x;
      mplier_d = {1'b0, mplier_q[W-1:1]};
      step_d   = step_q - 1'b1;
      if (step_q == '0) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      step_q   <= '0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      acc_q    <= acc_d;
      step_q   <= step_d;
      run_q    <= run_d;
      done_q   <= done_d;
    end
  end

  assign done    = done_q;
  assign product = acc_q;

endmodule

// File: rtl/sbx_pow_seq.sv
module sbx_pow_seq #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] base_in,
  input  logic         mul_done,
  input  logic [W-1:0] mul_prod,
  output logic         mul_start,
  output logic [W-1:0] mul_a,
  output logic [W-1:0] mul_b,
  output logic         fin
);

  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;
  // exponent 2^W - 2: all ones except bit 0
  localparam logic [W-1:0]  EXPO     = {{(W-1){1'b1}}, 1'b0};
  localparam logic [IW-1:0] TOP_IDX  = IW'(W - 2);

  logic [W-1:0]  base_q, base_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          mphase_q, mphase_d;
  logic          active_q, active_d;
  logic          step_end;
  logic          last_op;
  logic          want_mul;

  always_comb begin
    step_end = mul_done & active_q;
    want_mul = ~mphase_q & EXPO[idx_q];
    last_op  = (idx_q == '0) & ~want_mul;
    fin      = step_end & last_op;
  end

  always_comb begin
    mul_start = go | (step_end & ~last_op);
    if (go) begin
      mul_a = base_in;
      mul_b = base_in;
    end else if (want_mul) begin
      mul_a = mul_prod;
      mul_b = base_q;
    end else begin
      mul_a = mul_prod;
      mul_b = mul_prod;
    end
  end

  always_comb begin
    base_d   = base_q;
    idx_d    = idx_q;
    mphase_d = mphase_q;
    active_d = active_q;
    if (go) begin
      base_d   = base_in;
      idx_d    = TOP_IDX;
      mphase_d = 1'b0;
      active_d = 1'b1;
    end else if (step_end) begin
      if (last_op) begin
        active_d = 1'b0;
      end else if (want_mul) begin
        mphase_d = 1'b1;
      end else begin
        mphase_d = 1'b0;
        idx_d    = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      idx_q    <= '0;
      mphase_q <= 1'b0;
      active_q <= 1'b0;
    end else begin
      base_q   <= base_d;
      idx_q    <= idx_d;
      mphase_q <= mphase_d;
      active_q <= active_d;
    end
  end

endmodule

// File: rtl/sbx_affine.sv
module sbx_affine #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] CVAL = 8'h63
) (
  input  logic [W-1:0] inv_in,
  output logic [W-1:0] sub_out
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sub_out[i] = inv_in[i]
                      ^ inv_in[(i + 4) % W]
                      ^ inv_in[(i + 5) % W]
                      ^ inv_in[(i + 6) % W]
                      ^ inv_in[(i + 7) % W]
                      ^ CVAL[i];
  end

endmodule

// File: rtl/sbox_fermat_unit.sv
module sbox_fermat_unit
  import sbx_pkg::*;
#(
  parameter int unsigned        W     = SBX_W,
  parameter logic [W-1:0]       POLY  = 8'h1B,
  parameter logic [W-1:0]       CVAL  = 8'h63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_byte,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_byte
);

  logic         rst_int_n;
  sbx_state_e   state_q, state_d;
  logic [W-1:0] res_q, res_d;
  logic         accept;
  logic         give;
  logic         mul_start;
  logic [W-1:0] mul_a, mul_b, mul_prod;
  logic         mul_done;
  logic         fin;
  logic [W-1:0] sub_val;

  sbx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  always_comb begin
    accept = in_valid & (state_q == ST_IDLE);
    give   = out_ready & (state_q == ST_HOLD);
  end

  sbx_pow_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .go        (accept),
    .base_in   (in_byte),
    .mul_done  (mul_done),
    .mul_prod  (mul_prod),
    .mul_start (mul_start),
    .mul_a     (mul_a),
    .mul_b     (mul_b),
    .fin       (fin)
  );

  gf_serial_mul #(.W(W), .POLY(POLY)) u_mul (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (mul_start),
    .op_a    (mul_a),
    .op_b    (mul_b),
    .done    (mul_done),
    .product (mul_prod)
  );

  sbx_affine #(.W(W), .CVAL(CVAL)) u_aff (
    .inv_in  (mul_prod),
    .sub_out (sub_val)
  );

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      ST_BOOT: state_d = ST_IDLE;
      ST_IDLE: if (accept) state_d = ST_CALC;
      ST_CALC: begin
        if (fin) begin
          state_d = ST_HOLD;
          res_d   = sub_val;
        end
      end
      ST_HOLD: if (give) state_d = ST_IDLE;
      default: state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_BOOT;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign out_byte  = res_q;

endmodule

// File: rtl/sbox_fermat_chk.sv
module sbox_fermat_chk #(
  parameter int unsigned W   = 8,
  parameter int unsigned LAT = 117
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_byte,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_byte
);

  logic        busy_q;
  logic        zero_q;
  logic [15:0] lat_q;
  logic        acc;

  assign acc = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      zero_q <= 1'b0;
      lat_q  <= '0;
    end else if (acc) begin
      busy_q <= 1'b1;
      zero_q <= (in_byte == '0);
      lat_q  <= '0;
    end else if (busy_q && !out_valid) begin
      lat_q  <= lat_q + 1'b1;
    end else if (out_valid && out_ready) begin
      busy_q <= 1'b0;
    end
  end

  AST_RDY_VLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R2

  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready); // R2

  AST_FIXED_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $rose(out_valid)) |-> (lat_q == 16'(LAT))); // R6

  AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && zero_q && $rose(out_valid)) |-> (out_byte == W'(8'h63))); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R7

  AST_READY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready); // R8

endmodule

bind sbox_fermat_unit sbox_fermat_chk #(.W(W), .LAT(13 * (W + 1))) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_byte   (in_byte),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_byte  (out_byte)
);

// File: tb/sim_sbox_fermat_unit.sv
`timescale 1ns/1ps
module sim_sbox_fermat_unit;

  localparam int LAT = 117;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_byte;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_byte;

  int n_chk;
  int n_err;
  int cyc;
  bit chk_en;

  // reference model state
  int       m_boot;
  bit       m_busy;
  bit       m_valid;
  int       m_cnt;
  logic [7:0] m_exp;

  sbox_fermat_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int fmul(input int a, input int b);
    int p = 0;
    int x = a;
    for (int k = 0; k < 8; k++) begin
      if ((b >> k) & 1) p = p ^ x;
      x = x << 1;
      if (x & 256) x = x ^ 'h11B;
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox_ref(input logic [7:0] v);
    int inv = 0;
    int r = 0;
    if (v != 0) begin
      for (int y = 1; y < 256; y++) begin
        if (fmul(int'(v), y) == 1) inv = y;
      end
    end
    for (int i = 0; i < 8; i++) begin
      int bitv = ((inv >> i) & 1) ^ ((inv >> ((i + 4) % 8)) & 1)
               ^ ((inv >> ((i + 5) % 8)) & 1) ^ ((inv >> ((i + 6) % 8)) & 1)
               ^ ((inv >> ((i + 7) % 8)) & 1) ^ (('h63 >> i) & 1);
      r = r | (bitv << i);
    end
    return 8'(r);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_boot  = 3;
      m_busy  = 0;
      m_valid = 0;
      m_cnt   = 0;
      m_exp   = 8'h00;
    end else begin
      if (m_boot > 0) begin
        m_boot = m_boot - 1;
      end else if (m_valid) begin
        if (out_ready) m_valid = 0;
      end else if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy  = 0;
          m_valid = 1;
        end
      end else if (in_valid) begin
        m_busy = 1;
        m_cnt  = LAT;
        m_exp  = sbox_ref(in_byte);
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (chk_en) begin
      check(in_ready == (m_boot == 0 && !m_busy && !m_valid), "R2 in_ready",
            int'(in_ready), int'(m_boot == 0 && !m_busy && !m_valid));
      check(out_valid == m_valid, "R6 out_valid timing", int'(out_valid), int'(m_valid));
      if (m_valid) check(out_byte == m_exp, "R3 out_byte", int'(out_byte), int'(m_exp));
    end
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic push(input logic [7:0] b, input bit junk);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    if (junk) begin
      // R8: activity on the input side during a computation
      in_byte = ~b;
      repeat (20) @(negedge clk);
    end
    in_valid = 1'b0;
    in_byte  = 8'h00;
  endtask

  task automatic pull(input int stall, input logic [7:0] want, input string req);
    logic [7:0] held;
    while (!out_valid) @(negedge clk);
    check(out_byte == want, req, int'(out_byte), int'(want));
    held = out_byte;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(out_valid && out_byte == held, "R7 hold", int'(out_byte), int'(held));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready == 1'b1, "R8 ready after take", int'(in_ready), 1);
  endtask

  initial begin
    n_chk = 0; n_err = 0; cyc = 0; chk_en = 0;
    in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R1 in_ready in reset", int'(in_ready), 0);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    chk_en = 1;
    @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R1 ready before boot", int'(in_ready), 0);
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after boot", int'(in_ready), 1);

    push(8'h00, 0); pull(0, 8'h63, "R4 zero input");
    push(8'h01, 0); pull(0, 8'h7C, "R5 one input");
    push(8'h53, 0); pull(5, 8'hED, "R5 0x53 input");
    push(8'hFF, 1); pull(2, sbox_ref(8'hFF), "R8 junk ignored FF");
    push(8'h80, 1); pull(0, sbox_ref(8'h80), "R8 junk ignored 80");
    push(8'h02, 0); pull(1, sbox_ref(8'h02), "R3 0x02");
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 5) & 255);
      push(v, i[0]);
      pull(i % 3, sbox_ref(v), "R3 sweep");
    end

    repeat (4) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule